// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block drives an external multi-channel converter through a programmed run of conversion slots. Software programs a first slot, a last slot (included in the run) and a first data-buffer address. It then writes 1 to the busy bit. The controller walks the slots in order. For each slot it optionally waits through an extended acquisition phase, then requests one conversion. It writes the result into a 16-entry data buffer at an advancing write pointer.

A run either ends by itself after the last slot (single mode) or repeats until software stops it (continuous mode). A software stop lets a conversion already in flight finish and store its result. During an acquisition wait, the same stop aborts at once. Entry to a low-power mode forces the controller idle. A read-only field reports the buffer location written most recently. A data-available flag, gated by an enable, forms the interrupt.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, busy_o, conv_req_o, buf_we_o, flag_o, irq_o, last_addr_o, first_addr_o, start_slot_o and end_slot_o are all 0.
- R2: A busy write of 1 while idle (busy_we_i=1, busy_wd_i=1) sets busy_o at that clock edge. The slots are then converted in order from start_slot_o to end_slot_o inclusive. conv_slot_o names the slot being converted, and conv_req_o is never 1 while busy_o is 0.
- R3: In single mode (cont_mode_i=0), busy_o clears at the edge that stores the result of the end slot.
- R4: In continuous mode (cont_mode_i=1), the run repeats from the start slot after the end slot, and the write pointer reloads with first_addr_o on every repeat.
- R5: A busy write of 0 while a conversion is requested lets that conversion complete and be stored; busy_o clears at the edge that stores it.
- R6: A busy write of 0 during an acquisition wait clears busy_o at that edge, with no conversion request and no buffer write.
- R7: stop_mode_i=1 forces busy_o and conv_req_o to 0 at the next edge, whatever the phase.
- R8: Writes to first_addr_o, start_slot_o and end_slot_o (addr_we_i=1) take effect only while busy_o is 0. The fields can always be read.
- R9: The first result of a run goes to first_addr_o. Each later result goes to the next address, wrapping from 15 to 0. After each write, last_addr_o holds the address written.
- R10: With eos_only_i=0, flag_o sets at every buffer write. With eos_only_i=1, it sets only at the write of the end slot.
- R11: flag_o clears on flag_clr_i=1 and on a busy write that starts a run. A buffer write in the same cycle as flag_clr_i wins.
- R12: irq_o is 1 exactly when flag_o is 1 and irq_en_i is 1.
- R13: When start_slot_o is greater than end_slot_o, the slot index wraps from 7 to 0 and continues up to end_slot_o.
- R14: A slot whose bit is set in ext_acq_mask_i is preceded by ACQ_CYCLES cycles of acquisition wait, with conv_req_o at 0. A slot whose bit is clear is requested in the cycle after it is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stop_mode_i | input | 1 | Low-power entry, forces idle |
| busy_we_i | input | 1 | Write strobe for the busy bit |
| busy_wd_i | input | 1 | Value written to the busy bit |
| cont_mode_i | input | 1 | 1 = continuous, 0 = single run |
| eos_only_i | input | 1 | Flag only at end slot |
| flag_clr_i | input | 1 | Software clear of the flag |
| irq_en_i | input | 1 | Interrupt enable |
| addr_we_i | input | 1 | Write strobe for address fields |
| first_addr_wd_i | input | 4 | New first buffer address |
| start_slot_wd_i | input | 3 | New start slot |
| end_slot_wd_i | input | 3 | New end slot |
| ext_acq_mask_i | input | 8 | Per-slot extended acquisition enable |
| conv_done_i | input | 1 | Converter result valid (one cycle) |
| conv_data_i | input | DW | Converter result |
| busy_o | output | 1 | Busy bit |
| first_addr_o | output | 4 | First buffer address field |
| start_slot_o | output | 3 | Start slot field |
| end_slot_o | output | 3 | End slot field |
| last_addr_o | output | 4 | Buffer location last written |
| flag_o | output | 1 | Data-available flag |
| irq_o | output | 1 | Interrupt |
| conv_req_o | output | 1 | Conversion request, held until done |
| conv_slot_o | output | 3 | Slot being acquired or converted |
| buf_we_o | output | 1 | Buffer write strobe |
| buf_addr_o | output | 4 | Buffer write address |
| buf_data_o | output | DW | Buffer write data |

## Verification
Control writes are held over one rising edge, and their effects are sampled at the next falling edge. Busy, the address fields and the flag are registered, so they are due one edge after the strobe. Buffer writes are combinational with conv_done_i and are logged at the falling edge before the storing edge. last_addr_o and the flag follow at that edge. The acquisition length is measured by counting falling edges with busy set and no request. irq_o is combinational, so it is checked a moment after irq_en_i changes.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACQ  = 2'd1,
    ST_CONV = 2'd2
  } seq_state_e;
endpackage

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int NSLOT      = 8,
  parameter int ACQ_CYCLES = 8,
  localparam int SW = $clog2(NSLOT),
  localparam int CW = (ACQ_CYCLES > 1) ? $clog2(ACQ_CYCLES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stop_mode_i,
  input  logic             busy_we_i,
  input  logic             busy_wd_i,
  input  logic             cont_i,
  input  logic [SW-1:0]    start_slot_i,
  input  logic [SW-1:0]    end_slot_i,
  input  logic [NSLOT-1:0] ext_acq_mask_i,
  input  logic             conv_done_i,
  output seq_state_e       state_o,
  output logic [SW-1:0]    slot_o,
  output logic             store_o,
  output logic             end_store_o,
  output logic             start_evt_o,
  output logic             seq_load_o
);
  localparam logic [CW-1:0] CNT_LOAD = CW'(ACQ_CYCLES - 1);

  seq_state_e    state_q;
  logic [SW-1:0] slot_q, slot_inc, slot_nxt;
  logic [CW-1:0] cnt_q;
  logic          stop_pend_q;
  logic          stop_wr, stop_now, at_end, repeat_seq, finish;

  assign start_evt_o = busy_we_i & busy_wd_i & (state_q == ST_IDLE) & ~stop_mode_i;
  assign stop_wr     = busy_we_i & ~busy_wd_i & (state_q != ST_IDLE);
  assign store_o     = (state_q == ST_CONV) & conv_done_i & ~stop_mode_i;
  assign at_end      = (slot_q == end_slot_i);
  assign end_store_o = store_o & at_end;
  assign stop_now    = stop_pend_q | stop_wr;
  assign repeat_seq  = end_store_o & cont_i & ~stop_now;
  assign finish      = store_o & (stop_now | (at_end & ~cont_i));
  assign seq_load_o  = start_evt_o | repeat_seq;

  assign slot_inc = (slot_q == SW'(NSLOT - 1)) ? '0 : slot_q + 1'b1;
  assign slot_nxt = repeat_seq ? start_slot_i : slot_inc;

  assign state_o = state_q;
  assign slot_o  = slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      slot_q      <= '0;
      cnt_q       <= '0;
      stop_pend_q <= 1'b0;
    end else if (stop_mode_i) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      stop_pend_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_evt_o) begin
            slot_q  <= start_slot_i;
            cnt_q   <= CNT_LOAD;
            state_q <= ext_acq_mask_i[start_slot_i] ? ST_ACQ : ST_CONV;
          end
        end
        ST_ACQ: begin
          // abort at once while waiting
          if (stop_wr)             state_q <= ST_IDLE;
          else if (cnt_q == '0)    state_q <= ST_CONV;
          else                     cnt_q   <= cnt_q - 1'b1;
        end
        ST_CONV: begin
          if (stop_wr) stop_pend_q <= 1'b1;
          if (store_o) begin
            if (finish) begin
              state_q     <= ST_IDLE;
              stop_pend_q <= 1'b0;
            end else begin
              slot_q  <= slot_nxt;
              cnt_q   <= CNT_LOAD;
              state_q <= ext_acq_mask_i[slot_nxt] ? ST_ACQ : ST_CONV;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_wptr.sv
module adc_seq_wptr #(
  parameter int NBUF = 16,
  localparam int AW = $clog2(NBUF)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          store_i,
  input  logic [AW-1:0] first_addr_i,
  output logic [AW-1:0] ptr_o,
  output logic [AW-1:0] last_addr_o
);
  logic [AW-1:0] ptr_q, last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      last_q <= '0;
    end else begin
      if (store_i) last_q <= ptr_q;
      if (load_i)       ptr_q <= first_addr_i;
      else if (store_i) ptr_q <= (ptr_q == AW'(NBUF - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  assign ptr_o       = ptr_q;
  assign last_addr_o = last_q;
endmodule

// File: rtl/adc_seq_flag.sv
module adc_seq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic store_i,
  input  logic end_store_i,
  input  logic eos_only_i,
  input  logic clr_i,
  input  logic start_evt_i,
  input  logic irq_en_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q, set;

  assign set = eos_only_i ? end_store_i : store_i;

  // a new result beats a concurrent clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  flag_q <= 1'b0;
    else if (set)                 flag_q <= 1'b1;
    else if (clr_i | start_evt_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & irq_en_i;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NSLOT      = 8,
  parameter int NBUF       = 16,
  parameter int DW         = 12,
  parameter int ACQ_CYCLES = 8,
  localparam int SW = $clog2(NSLOT),
  localparam int AW = $clog2(NBUF)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stop_mode_i,
  input  logic             busy_we_i,
  input  logic             busy_wd_i,
  input  logic             cont_mode_i,
  input  logic             eos_only_i,
  input  logic             flag_clr_i,
  input  logic             irq_en_i,
  input  logic             addr_we_i,
  input  logic [AW-1:0]    first_addr_wd_i,
  input  logic [SW-1:0]    start_slot_wd_i,
  input  logic [SW-1:0]    end_slot_wd_i,
  input  logic [NSLOT-1:0] ext_acq_mask_i,
  input  logic             conv_done_i,
  input  logic [DW-1:0]    conv_data_i,
  output logic             busy_o,
  output logic [AW-1:0]    first_addr_o,
  output logic [SW-1:0]    start_slot_o,
  output logic [SW-1:0]    end_slot_o,
  output logic [AW-1:0]    last_addr_o,
  output logic             flag_o,
  output logic             irq_o,
  output logic             conv_req_o,
  output logic [SW-1:0]    conv_slot_o,
  output logic             buf_we_o,
  output logic [AW-1:0]    buf_addr_o,
  output logic [DW-1:0]    buf_data_o
);
  seq_state_e    state;
  logic [SW-1:0] slot;
  logic [AW-1:0] ptr;
  logic          store, end_store, start_evt, seq_load, in_acq;
  logic [AW-1:0] first_q;
  logic [SW-1:0] start_q, end_q;

  // address fields, locked while busy
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q <= '0;
      start_q <= '0;
      end_q   <= '0;
    end else if (addr_we_i && state == ST_IDLE) begin
      first_q <= first_addr_wd_i;
      start_q <= start_slot_wd_i;
      end_q   <= end_slot_wd_i;
    end
  end

  adc_seq_fsm #(.NSLOT(NSLOT), .ACQ_CYCLES(ACQ_CYCLES)) u_fsm (
    .clk_i, .rst_ni, .stop_mode_i, .busy_we_i, .busy_wd_i,
    .cont_i         (cont_mode_i),
    .start_slot_i   (start_q),
    .end_slot_i     (end_q),
    .ext_acq_mask_i,
    .conv_done_i,
    .state_o        (state),
    .slot_o         (slot),
    .store_o        (store),
    .end_store_o    (end_store),
    .start_evt_o    (start_evt),
    .seq_load_o     (seq_load)
  );

  adc_seq_wptr #(.NBUF(NBUF)) u_wptr (
    .clk_i, .rst_ni,
    .load_i       (seq_load),
    .store_i      (store),
    .first_addr_i (first_q),
    .ptr_o        (ptr),
    .last_addr_o
  );

  adc_seq_flag u_flag (
    .clk_i, .rst_ni,
    .store_i     (store),
    .end_store_i (end_store),
    .eos_only_i,
    .clr_i       (flag_clr_i),
    .start_evt_i (start_evt),
    .irq_en_i,
    .flag_o,
    .irq_o
  );

  assign in_acq       = (state == ST_ACQ);
  assign busy_o       = (state != ST_IDLE);
  assign conv_req_o   = (state == ST_CONV);
  assign conv_slot_o  = slot;
  assign buf_we_o     = store;
  assign buf_addr_o   = ptr;
  assign buf_data_o   = conv_data_i;
  assign first_addr_o = first_q;
  assign start_slot_o = start_q;
  assign end_slot_o   = end_q;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int AW = 4,
  parameter int SW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          stop_mode_i,
  input logic          busy_we_i,
  input logic          busy_wd_i,
  input logic          cont_mode_i,
  input logic          eos_only_i,
  input logic          flag_clr_i,
  input logic          irq_en_i,
  input logic          busy_o,
  input logic [AW-1:0] first_addr_o,
  input logic [SW-1:0] start_slot_o,
  input logic [SW-1:0] end_slot_o,
  input logic [AW-1:0] last_addr_o,
  input logic          flag_o,
  input logic          irq_o,
  input logic          conv_req_o,
  input logic [SW-1:0] conv_slot_o,
  input logic          buf_we_o,
  input logic [AW-1:0] buf_addr_o,
  input logic          in_acq_i
);
  assert_req_needs_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |-> busy_o);

  assert_single_end_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_we_o && !cont_mode_i && conv_slot_o == end_slot_o) |=> !busy_o);

  assert_acq_abort_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_acq_i && busy_we_i && !busy_wd_i && !stop_mode_i) |=> (!busy_o && !conv_req_o));

  assert_stop_mode_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_mode_i |=> (!busy_o && !conv_req_o));

  assert_fields_locked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(first_addr_o) && $stable(start_slot_o) && $stable(end_slot_o)));

  assert_last_addr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we_o |=> (last_addr_o == $past(buf_addr_o)));

  assert_flag_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_we_o && !eos_only_i) |=> flag_o);

  assert_flag_clr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && !buf_we_o) |=> !flag_o);

  assert_irq_gate_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !irq_o);
endmodule

bind adc_seq_ctrl adc_seq_chk #(.AW(AW), .SW(SW)) u_chk (
  .clk_i, .rst_ni, .stop_mode_i, .busy_we_i, .busy_wd_i, .cont_mode_i,
  .eos_only_i, .flag_clr_i, .irq_en_i, .busy_o, .first_addr_o,
  .start_slot_o, .end_slot_o, .last_addr_o, .flag_o, .irq_o,
  .conv_req_o, .conv_slot_o, .buf_we_o, .buf_addr_o,
  .in_acq_i (in_acq)
);

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
  localparam int ACQ = 6;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic        stop_mode = 0, busy_we = 0, busy_wd = 0, cont = 0, eos = 0;
  logic        fclr = 0, irq_en = 0, addr_we = 0;
  logic [3:0]  first_wd = 0;
  logic [2:0]  start_wd = 0, end_wd = 0;
  logic [7:0]  mask = 0;
  logic        done = 0;
  logic [11:0] cdata = 0;
  logic        busy, flag, irq, req, bwe;
  logic [3:0]  first_rd, last_addr, baddr;
  logic [2:0]  start_rd, end_rd, cslot;
  logic [11:0] bdata;

  adc_seq_ctrl #(.ACQ_CYCLES(ACQ)) u0 (
    .clk_i(clk), .rst_ni, .stop_mode_i(stop_mode), .busy_we_i(busy_we),
    .busy_wd_i(busy_wd), .cont_mode_i(cont), .eos_only_i(eos),
    .flag_clr_i(fclr), .irq_en_i(irq_en), .addr_we_i(addr_we),
    .first_addr_wd_i(first_wd), .start_slot_wd_i(start_wd),
    .end_slot_wd_i(end_wd), .ext_acq_mask_i(mask), .conv_done_i(done),
    .conv_data_i(cdata), .busy_o(busy), .first_addr_o(first_rd),
    .start_slot_o(start_rd), .end_slot_o(end_rd), .last_addr_o(last_addr),
    .flag_o(flag), .irq_o(irq), .conv_req_o(req), .conv_slot_o(cslot),
    .buf_we_o(bwe), .buf_addr_o(baddr), .buf_data_o(bdata)
  );

  // converter stub: result LAT cycles after request, data tags the slot
  int lat_cnt = 0, nconv = 0;
  always @(posedge clk) begin
    done <= 1'b0;
    if (req && !done) begin
      if (lat_cnt == LAT - 1) begin
        done    <= 1'b1;
        cdata   <= {cslot, 9'(nconv)};
        nconv   <= nconv + 1;
        lat_cnt <= 0;
      end else lat_cnt <= lat_cnt + 1;
    end else lat_cnt <= 0;
  end

  // write log and request-rise counter
  int nw = 0, nreq = 0;
  logic [3:0]  wa [256];
  logic [11:0] wd [256];
  logic req_prev = 0;
  always @(negedge clk) begin
    if (bwe) begin wa[nw] = baddr; wd[nw] = bdata; nw = nw + 1; end
    if (req && !req_prev) nreq = nreq + 1;
    req_prev = req;
  end

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [3:0] f, input logic [2:0] s, input logic [2:0] e);
    @(negedge clk); addr_we = 1; first_wd = f; start_wd = s; end_wd = e;
    @(negedge clk); addr_we = 0;
  endtask

  task automatic wr_busy(input logic v);
    @(negedge clk); busy_we = 1; busy_wd = v;
    @(negedge clk); busy_we = 0;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 2000 && busy; n++) @(negedge clk);
  endtask

  // {first, start, end, count, last}
  localparam logic [18:0] VEC [5] = '{
    {4'd0,  3'd0, 3'd7, 5'd8, 4'd7},
    {4'd14, 3'd2, 3'd4, 5'd3, 4'd0},
    {4'd5,  3'd6, 3'd1, 5'd4, 4'd8},
    {4'd3,  3'd5, 3'd5, 5'd1, 4'd3},
    {4'd15, 3'd7, 3'd0, 5'd2, 4'd0}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !req && !bwe, "R1 busy/req/we", int'(busy), 0);
    chk(!flag && !irq, "R1 flag/irq", int'(flag), 0);
    chk(last_addr == 0 && first_rd == 0 && start_rd == 0 && end_rd == 0,
        "R1 fields", int'(last_addr), 0);
    rst_ni = 1;
    @(negedge clk);

    // table walk: single runs, R2 R3 R9 R10 R13
    for (int v = 0; v < 5; v++) begin
      logic [3:0] f, la; logic [2:0] s, e; logic [4:0] cn;
      int base;
      {f, s, e, cn, la} = VEC[v];
      cfg(f, s, e);
      base = nw;
      wr_busy(1);
      chk(busy, "R2 busy set", int'(busy), 1);
      wait_idle();
      @(negedge clk);
      chk(nw - base == int'(cn), "R2/R13 result count", nw - base, int'(cn));
      for (int k = 0; k < int'(cn) && k < nw - base; k++) begin
        chk(wa[base+k] == 4'(f + k), "R9 write address", int'(wa[base+k]), int'(4'(f + k)));
        chk(wd[base+k][11:9] == 3'(s + k), "R13 slot order", int'(wd[base+k][11:9]),
            int'(3'(s + k)));
      end
      chk(last_addr == la, "R9 last address", int'(last_addr), int'(la));
      chk(!busy, "R3 single-run busy clear", int'(busy), 0);
      chk(flag, "R10 flag set per result", int'(flag), 1);
    end

    // R12 interrupt gating
    irq_en = 0; #1;
    chk(!irq, "R12 irq masked", int'(irq), 0);
    irq_en = 1; #1;
    chk(irq, "R12 irq enabled", int'(irq), 1);
    // R11 software clear
    @(negedge clk); fclr = 1; @(negedge clk); fclr = 0;
    chk(!flag && !irq, "R11 clear by write", int'(flag), 0);

    // R8 field lock while busy
    cfg(4'd2, 3'd0, 3'd7);
    wr_busy(1);
    cfg(4'd9, 3'd3, 3'd4);
    chk(first_rd == 2 && start_rd == 0 && end_rd == 7, "R8 locked while busy",
        int'(first_rd), 2);
    wait_idle();
    // R11 start clears flag
    chk(flag, "R10 flag before restart", int'(flag), 1);
    cfg(4'd9, 3'd3, 3'd4);
    chk(first_rd == 9 && start_rd == 3 && end_rd == 4, "R8 write when idle",
        int'(first_rd), 9);
    wr_busy(1);
    chk(!flag, "R11 start clears flag", int'(flag), 1'b0);
    wait_idle();

    // R4 continuous with pointer reload, R5 stop completes conversion
    begin
      int base;
      cfg(4'd13, 3'd1, 3'd3);
      cont = 1;
      base = nw;
      wr_busy(1);
      for (int n = 0; n < 500 && nw - base < 7; n++) @(negedge clk);
      @(negedge clk);
      wr_busy(0);
      chk(busy, "R5 busy held during conversion", int'(busy), 1);
      wait_idle();
      @(negedge clk);
      cont = 0;
      chk(nw - base == 8, "R5 in-flight result stored", nw - base, 8);
      for (int k = 0; k < 8; k++)
        chk(wa[base+k] == 4'(13 + (k % 3)), "R4 pointer reload", int'(wa[base+k]),
            int'(4'(13 + (k % 3))));
      chk(last_addr == 14, "R4 last address", int'(last_addr), 14);
    end

    // R6 stop during acquisition wait aborts immediately
    begin
      int base, rq;
      mask = 8'hFF;
      cfg(4'd0, 3'd0, 3'd1);
      base = nw; rq = nreq;
      wr_busy(1);
      wr_busy(0);
      chk(!busy, "R6 abort in acquisition", int'(busy), 0);
      repeat (10) @(negedge clk);
      chk(nw == base && nreq == rq, "R6 no request or write", nw - base, 0);
    end

    // R14 acquisition length
    begin
      int n;
      mask = 8'h04;
      cfg(4'd0, 3'd2, 3'd2);
      wr_busy(1);
      n = 0;
      while (!req && n < 100) begin n++; @(negedge clk); end
      chk(n == ACQ, "R14 masked slot wait", n, ACQ);
      wait_idle();
      mask = 8'h00;
      wr_busy(1);
      n = 0;
      while (!req && n < 100) begin n++; @(negedge clk); end
      chk(n == 0, "R14 unmasked slot no wait", n, 0);
      wait_idle();
    end

    // R10 end-of-run only
    begin
      int base;
      eos = 1;
      cfg(4'd0, 3'd0, 3'd3);
      base = nw;
      wr_busy(1);
      for (int n = 0; n < 200 && nw - base < 1; n++) @(negedge clk);
      @(negedge clk);
      chk(!flag, "R10 no flag mid-run", int'(flag), 0);
      wait_idle();
      chk(flag, "R10 flag at end slot", int'(flag), 1);
      eos = 0;
    end

    // R7 low-power entry
    cfg(4'd0, 3'd0, 3'd7);
    wr_busy(1);
    repeat (5) @(negedge clk);
    stop_mode = 1; @(negedge clk); stop_mode = 0;
    chk(!busy && !req, "R7 forced idle", int'(busy), 0);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule